// File: doc/BRIEF.md
# Multiprocessor-Mode UART Receiver

This block receives asynchronous serial frames from a single line and hands each byte to a data register with status flags. The bit timing comes from an external tick that pulses sixteen times per bit period. Each bit is sampled once, near the middle of its period. A frame is one low start bit, the data bits with the least significant first, an optional extra bit, and one high stop bit. The extra bit is the multiprocessor bit when multiprocessor format is selected. Otherwise it is a parity bit, present only when parity is enabled.

Several stations can share one line. To support that, software can arm a wake enable. While it is armed in multiprocessor format, every frame whose multiprocessor bit is 0 is dropped. A dropped frame gets no error checking, sets no flag and leaves the data register untouched. The first frame whose multiprocessor bit is 1 is accepted normally, sets the received-multiprocessor-bit status, and clears the wake enable by itself.

The block has four status flags: data ready, framing error, parity error and overrun. Each has its own one-cycle clear strobe, and a data-register read strobe also clears data ready. The receive and error interrupt requests are level outputs, each gated by its own enable input.

Top module: `mpx_uart_rx`

## Requirements
- R1: A frame is received only while `rx_en` is high. With `rx_en` low, a complete frame on `rxd` changes neither `rx_data` nor any flag. A frame in progress is abandoned when `rx_en` drops.
- R2: A low level on `rxd` that is high again at the middle of the start bit (tick count 8 of 16) is treated as a glitch and starts no frame. The next real frame is still received correctly.
- R3: When a frame ends with a high stop bit and no parity error, and `rdy` is clear, the data bits are loaded into `rx_data` (the first data bit received goes to bit 0) and `rdy` is set. In multiprocessor format, `rx_mpb` takes the value of the multiprocessor bit.
- R4: Dropping `rx_en` leaves `rdy`, `fer`, `per` and `ovr` unchanged.
- R5: While `wake_en` is 1 and `mp_fmt` is 1, a frame whose multiprocessor bit is 0 leaves `rx_data` unchanged and sets none of `rdy`, `fer` or `ovr`. This holds even when the frame's stop bit is low.
- R6: While `wake_en` is 1 and `mp_fmt` is 1, a frame whose multiprocessor bit is 1 is accepted as in R3, sets `rx_mpb` to 1, and clears `wake_en`.
- R7: With `mp_fmt` at 0, `wake_en` has no effect: frames are received normally and `wake_en` keeps its value.
- R8: A frame whose stop bit is low, received while `rdy` is clear, sets `fer`, loads `rx_data`, and does not set `rdy`.
- R9: With `mp_fmt` at 0 and `par_en` at 1, the extra bit is a parity bit: even parity when `par_odd` is 0, odd parity when it is 1. A mismatch sets `per` and does not set `rdy`. With `par_en` at 0, there is no extra bit.
- R10: A frame that completes while `rdy` is still set sets `ovr`. `rx_data` keeps its old contents, and `rdy` stays set.
- R11: `irq_rx` is high exactly when `rdy` is set and `rxi_en` is high. `irq_err` is high exactly when any of `fer`, `per` or `ovr` is set and `eri_en` is high.
- R12: Each flag is cleared by a one-cycle pulse on its clear strobe. A one-cycle pulse on `data_rd` also clears `rdy`. When a set and a clear arrive in the same cycle, the set wins.
- R13: After reset, `wake_en`, all flags, `rx_mpb`, `rx_data` and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receive enable |
| mp_fmt | input | 1 | 1: extra bit is the multiprocessor bit |
| par_en | input | 1 | Parity bit present when `mp_fmt` is 0 |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| wake_set | input | 1 | Strobe that arms `wake_en` |
| wake_clr | input | 1 | Strobe that disarms `wake_en` |
| rxi_en | input | 1 | Receive interrupt enable |
| eri_en | input | 1 | Error interrupt enable |
| data_rd | input | 1 | Data register read strobe, clears `rdy` |
| clr_rdy | input | 1 | Clear strobe for `rdy` |
| clr_fer | input | 1 | Clear strobe for `fer` |
| clr_per | input | 1 | Clear strobe for `per` |
| clr_ovr | input | 1 | Clear strobe for `ovr` |
| rx_data | output | DATA_BITS | Receive data register |
| rx_mpb | output | 1 | Last accepted multiprocessor bit |
| rdy | output | 1 | Data ready flag |
| fer | output | 1 | Framing error flag |
| per | output | 1 | Parity error flag |
| ovr | output | 1 | Overrun flag |
| wake_en | output | 1 | Wake enable status |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Receive error interrupt request |

## Verification
The bench builds the block with its defaults: eight data bits, sixteen ticks per bit and a two-stage input synchronizer. It holds `os_tick` high on every clock, so one bit lasts sixteen clocks and a whole frame takes under two hundred cycles. That short frame lets a single run cover wake arming, dropping, wake-up, overrun, framing and parity errors in both parity senses, and the frame format without an extra bit. A start glitch shorter than half a bit exercises the mid-bit rejection, and a frame cut short by dropping `rx_en` exercises the abort path.

// File: rtl/mpx_rx_pkg.sv
// Shared types for the multiprocessor-mode receiver.
// Assumes: used by every module of the receiver, compiled first.
package mpx_rx_pkg;

    // Receiver frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_EXTRA = 3'd3,
        ST_STOP  = 3'd4,
        ST_BREAK = 3'd5
    } rx_state_t;

    // Status flag bundle
    typedef struct packed {
        logic rdy;
        logic fer;
        logic per;
        logic ovr;
    } rx_flags_t;

endpackage

// File: rtl/mpx_rx_sync.sv
// Input synchronizer for the asynchronous serial line.
// Does: passes rxd through STAGES flops; resets to the idle level.
// Assumes: STAGES >= 1.
module mpx_rx_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 1) begin : g_single
            logic r;
            // Single flop resample
            always_ff @(posedge clk) begin
                if (!rst_n) r <= IDLE_LVL;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            // Shift chain toward the MSB
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{IDLE_LVL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/mpx_rx_frame.sv
// Frame sequencer and receive shift register.
// Does: detects a start bit, rejects it as a glitch if the line is high
// again at mid start bit, samples each following bit at mid period,
// and emits a one-cycle done pulse carrying data, extra bit and stop level.
// Assumes: os_tick pulses OVS times per bit; rxd_s is synchronous.
// After a low stop bit, waits for the line to return high before idle.
module mpx_rx_frame
    import mpx_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd_s,
    input  logic                 rx_en,
    input  logic                 extra_en,
    output logic                 frm_done,
    output logic [DATA_BITS-1:0] frm_data,
    output logic                 frm_extra,
    output logic                 frm_stop
);

    localparam int CW       = $clog2(OVS);
    localparam int IW       = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] MID_CNT  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);
    localparam logic [IW-1:0] LAST_BIT = IW'(DATA_BITS - 1);

    rx_state_t            state;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 extra_q;
    logic                 stop_q;
    logic                 done_q;
    logic                 at_last;
    logic                 at_mid;

    // Decode of the tick counter position
    always_comb begin
        at_last = (cnt == LAST_CNT);
        at_mid  = (cnt == MID_CNT);
    end

    // Frame sequencing, bit sampling and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            extra_q <= 1'b0;
            stop_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!rx_en) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else if (os_tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (at_mid) begin
                            cnt <= '0;
                            if (rxd_s) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_last) begin
                            cnt   <= '0;
                            shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
                            if (bit_idx == LAST_BIT) begin
                                state <= extra_en ? ST_EXTRA : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_EXTRA: begin
                        if (at_last) begin
                            cnt     <= '0;
                            extra_q <= rxd_s;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_last) begin
                            cnt    <= '0;
                            stop_q <= rxd_s;
                            done_q <= 1'b1;
                            state  <= rxd_s ? ST_IDLE : ST_BREAK;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BREAK: begin
                        if (rxd_s) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign frm_done  = done_q;
    assign frm_data  = shreg;
    assign frm_extra = extra_q;
    assign frm_stop  = stop_q;

endmodule

// File: rtl/mpx_rx_status.sv
// Wake filter, receive data register, status flags and wake enable.
// Does: drops frames with a zero multiprocessor bit while the wake enable
// is armed in multiprocessor format, auto-disarms on a one bit, loads the
// data register, and sets or clears the four flags.
// Assumes: frm_done is a one-cycle pulse; frame fields are stable with it.
module mpx_rx_status
    import mpx_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_done,
    input  logic [DATA_BITS-1:0] frm_data,
    input  logic                 frm_extra,
    input  logic                 frm_stop,
    input  logic                 mp_fmt,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 wake_set,
    input  logic                 wake_clr,
    input  logic                 data_rd,
    input  logic                 clr_rdy,
    input  logic                 clr_fer,
    input  logic                 clr_per,
    input  logic                 clr_ovr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_mpb,
    output rx_flags_t            flags,
    output logic                 wake_en
);

    logic [DATA_BITS-1:0] data_q;
    logic                 mpb_q;
    logic                 wake_q;
    rx_flags_t            flg_q;
    rx_flags_t            flg_d;
    logic                 parity_bad;
    logic                 drop_frame;
    logic                 wake_hit;
    logic                 accept;
    logic                 fresh;

    // Frame classification: parity, wake filter, acceptance
    always_comb begin
        parity_bad = !mp_fmt && par_en && ((^{frm_data, frm_extra}) != par_odd);
        drop_frame = mp_fmt && wake_q && !frm_extra;
        wake_hit   = frm_done && mp_fmt && wake_q && frm_extra;
        accept     = frm_done && !drop_frame;
        fresh      = accept && !flg_q.rdy;
    end

    // Next flag values: set has priority over clear
    always_comb begin
        flg_d.rdy = (flg_q.rdy & ~(clr_rdy | data_rd)) | (fresh & frm_stop & ~parity_bad);
        flg_d.fer = (flg_q.fer & ~clr_fer) | (fresh & ~frm_stop);
        flg_d.per = (flg_q.per & ~clr_per) | (fresh & parity_bad);
        flg_d.ovr = (flg_q.ovr & ~clr_ovr) | (accept & flg_q.rdy);
    end

    // Wake enable: armed by strobe, disarmed by strobe or wake frame
    always_ff @(posedge clk) begin
        if (!rst_n)                    wake_q <= 1'b0;
        else if (wake_clr || wake_hit) wake_q <= 1'b0;
        else if (wake_set)             wake_q <= 1'b1;
    end

    // Data register and multiprocessor bit status load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mpb_q  <= 1'b0;
        end else if (fresh) begin
            data_q <= frm_data;
            if (mp_fmt) mpb_q <= frm_extra;
        end
    end

    // Flag register update
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign rx_data = data_q;
    assign rx_mpb  = mpb_q;
    assign flags   = flg_q;
    assign wake_en = wake_q;

endmodule

// File: rtl/mpx_uart_rx.sv
// Top of the multiprocessor-mode asynchronous receiver.
// Does: synchronizes the line, sequences frames, filters and stores them,
// and gates the interrupt requests with their enables.
// Assumes: os_tick is supplied externally at OVS ticks per bit.
module mpx_uart_rx
    import mpx_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 rx_en,
    input  logic                 mp_fmt,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 wake_set,
    input  logic                 wake_clr,
    input  logic                 rxi_en,
    input  logic                 eri_en,
    input  logic                 data_rd,
    input  logic                 clr_rdy,
    input  logic                 clr_fer,
    input  logic                 clr_per,
    input  logic                 clr_ovr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_mpb,
    output logic                 rdy,
    output logic                 fer,
    output logic                 per,
    output logic                 ovr,
    output logic                 wake_en,
    output logic                 irq_rx,
    output logic                 irq_err
);

    logic                 rxd_s;
    logic                 extra_en;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_extra;
    logic                 frm_stop;
    rx_flags_t            flags;

    // Extra bit present in multiprocessor format or with parity
    assign extra_en = mp_fmt | par_en;

    mpx_rx_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (1'b1)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rxd_s)
    );

    mpx_rx_frame #(
        .DATA_BITS (DATA_BITS),
        .OVS       (OVS)
    ) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd_s     (rxd_s),
        .rx_en     (rx_en),
        .extra_en  (extra_en),
        .frm_done  (frm_done),
        .frm_data  (frm_data),
        .frm_extra (frm_extra),
        .frm_stop  (frm_stop)
    );

    mpx_rx_status #(
        .DATA_BITS (DATA_BITS)
    ) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_done  (frm_done),
        .frm_data  (frm_data),
        .frm_extra (frm_extra),
        .frm_stop  (frm_stop),
        .mp_fmt    (mp_fmt),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .wake_set  (wake_set),
        .wake_clr  (wake_clr),
        .data_rd   (data_rd),
        .clr_rdy   (clr_rdy),
        .clr_fer   (clr_fer),
        .clr_per   (clr_per),
        .clr_ovr   (clr_ovr),
        .rx_data   (rx_data),
        .rx_mpb    (rx_mpb),
        .flags     (flags),
        .wake_en   (wake_en)
    );

    // Flag outputs and enable-gated interrupt requests
    always_comb begin
        rdy     = flags.rdy;
        fer     = flags.fer;
        per     = flags.per;
        ovr     = flags.ovr;
        irq_rx  = flags.rdy & rxi_en;
        irq_err = (flags.fer | flags.per | flags.ovr) & eri_en;
    end

endmodule

// File: rtl/mpx_uart_rx_chk.sv
// Checker for the multiprocessor-mode receiver, bound to the top module.
// Does: checks port-level timing rules of enable, wake filter, overrun,
// interrupt gating and reset.
// Assumes: synchronous active-low reset; flag updates lag sampled inputs.
module mpx_uart_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 mp_fmt,
    input logic                 wake_clr,
    input logic                 rxi_en,
    input logic                 eri_en,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_mpb,
    input logic                 rdy,
    input logic                 fer,
    input logic                 per,
    input logic                 ovr,
    input logic                 wake_en,
    input logic                 irq_rx,
    input logic                 irq_err
);

    // R1: a flag can only rise two cycles after reception was enabled
    p_start_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy) || $rose(fer) || $rose(per) || $rose(ovr)) |-> $past(rx_en, 2));

    // R5: while armed in multiprocessor format and still armed, no flag rises
    p_wake_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en && mp_fmt) |=> (!wake_en || (!$rose(rdy) && !$rose(fer) && !$rose(ovr))));

    // R6: an automatic disarm comes with the multiprocessor bit status set
    p_wake_autoclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wake_en) && !$past(wake_clr)) |-> rx_mpb);

    // R10: overrun keeps the data register and data ready
    p_ovr_keeps_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($stable(rx_data) && rdy));

    // R11: no receive request without its enable
    p_irq_rx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rxi_en |-> !irq_rx);

    // R11: no error request without its enable
    p_irq_err_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !eri_en |-> !irq_err);

    // R13: the cycle after a reset edge everything is cleared
    p_reset_clear_r13: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rdy && !fer && !per && !ovr && !wake_en && !rx_mpb));

endmodule

bind mpx_uart_rx mpx_uart_rx_chk #(.DATA_BITS(DATA_BITS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .mp_fmt   (mp_fmt),
    .wake_clr (wake_clr),
    .rxi_en   (rxi_en),
    .eri_en   (eri_en),
    .rx_data  (rx_data),
    .rx_mpb   (rx_mpb),
    .rdy      (rdy),
    .fer      (fer),
    .per      (per),
    .ovr      (ovr),
    .wake_en  (wake_en),
    .irq_rx   (irq_rx),
    .irq_err  (irq_err)
);

// File: tb/test_mpx_uart_rx.sv
// Directed bench for the multiprocessor-mode receiver.
// One task per scenario; os_tick held high so one bit lasts 16 clocks.
module test_mpx_uart_rx;

    localparam int DW  = 8;
    localparam int BIT = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          os_tick = 1'b1;
    logic          rxd = 1'b1;
    logic          rx_en = 1'b0;
    logic          mp_fmt = 1'b1;
    logic          par_en = 1'b0;
    logic          par_odd = 1'b0;
    logic          wake_set = 1'b0;
    logic          wake_clr = 1'b0;
    logic          rxi_en = 1'b0;
    logic          eri_en = 1'b0;
    logic          data_rd = 1'b0;
    logic          clr_rdy = 1'b0;
    logic          clr_fer = 1'b0;
    logic          clr_per = 1'b0;
    logic          clr_ovr = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_mpb, rdy, fer, per, ovr, wake_en, irq_rx, irq_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mpx_uart_rx i_mpx_uart_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
        .mp_fmt(mp_fmt), .par_en(par_en), .par_odd(par_odd),
        .wake_set(wake_set), .wake_clr(wake_clr), .rxi_en(rxi_en), .eri_en(eri_en),
        .data_rd(data_rd), .clr_rdy(clr_rdy), .clr_fer(clr_fer), .clr_per(clr_per),
        .clr_ovr(clr_ovr), .rx_data(rx_data), .rx_mpb(rx_mpb), .rdy(rdy), .fer(fer),
        .per(per), .ovr(ovr), .wake_en(wake_en), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input logic [DW-1:0] d, input bit has_x,
                              input bit x, input bit stop);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < DW; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (has_x) begin
            rxd = x;
            repeat (BIT) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic read_data();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13", "rdy", rdy, 0);
        chk("R13", "fer|per|ovr", {fer, per, ovr}, 0);
        chk("R13", "wake_en", wake_en, 0);
        chk("R13", "rx_mpb", rx_mpb, 0);
        chk("R13", "rx_data", rx_data, 0);
        chk("R13", "irqs", {irq_rx, irq_err}, 0);
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        send_frame(8'h5A, 1, 0, 1);
        chk("R1", "rdy while disabled", rdy, 0);
        chk("R1", "data while disabled", rx_data, 0);
    endtask

    task automatic t_basic();
        rx_en = 1'b1;
        rxi_en = 1'b1;
        send_frame(8'hA5, 1, 1, 1);
        chk("R3", "rx_data", rx_data, 8'hA5);
        chk("R3", "rdy", rdy, 1);
        chk("R3", "rx_mpb one", rx_mpb, 1);
        chk("R11", "irq_rx on", irq_rx, 1);
        rxi_en = 1'b0;
        @(negedge clk);
        chk("R11", "irq_rx gated", irq_rx, 0);
        rxi_en = 1'b1;
        read_data();
        chk("R12", "rdy after read", rdy, 0);
        chk("R11", "irq_rx after read", irq_rx, 0);
        send_frame(8'h3C, 1, 0, 1);
        chk("R3", "rx_data 2", rx_data, 8'h3C);
        chk("R3", "rx_mpb zero", rx_mpb, 0);
        clr_rdy = 1'b1;
        @(negedge clk);
        clr_rdy = 1'b0;
        @(negedge clk);
        chk("R12", "rdy after clear", rdy, 0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk("R2", "glitch no rdy", rdy, 0);
        chk("R2", "glitch no fer", fer, 0);
        send_frame(8'h81, 1, 0, 1);
        chk("R2", "frame after glitch", rx_data, 8'h81);
        read_data();
    endtask

    task automatic t_overrun();
        eri_en = 1'b1;
        send_frame(8'h11, 1, 0, 1);
        send_frame(8'h22, 1, 0, 1);
        chk("R10", "ovr set", ovr, 1);
        chk("R10", "old data kept", rx_data, 8'h11);
        chk("R10", "rdy kept", rdy, 1);
        chk("R11", "irq_err", irq_err, 1);
        clr_ovr = 1'b1;
        @(negedge clk);
        clr_ovr = 1'b0;
        @(negedge clk);
        chk("R12", "ovr cleared", ovr, 0);
        chk("R11", "irq_err off", irq_err, 0);
        read_data();
    endtask

    task automatic t_framing();
        send_frame(8'h6E, 1, 0, 0);
        chk("R8", "fer", fer, 1);
        chk("R8", "rdy not set", rdy, 0);
        chk("R8", "data loaded", rx_data, 8'h6E);
    endtask

    task automatic t_rxen_clear();
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4", "fer kept", fer, 1);
        chk("R4", "rdy kept", rdy, 0);
        rx_en = 1'b1;
        rxd = 1'b0;
        repeat (5 * BIT) @(negedge clk);
        rx_en = 1'b0;
        rxd = 1'b1;
        repeat (8 * BIT) @(negedge clk);
        chk("R1", "aborted frame data", rx_data, 8'h6E);
        chk("R4", "flags after abort", {rdy, fer, per, ovr}, 4'b0100);
        rx_en = 1'b1;
        clr_fer = 1'b1;
        @(negedge clk);
        clr_fer = 1'b0;
        @(negedge clk);
        chk("R12", "fer cleared", fer, 0);
    endtask

    task automatic t_wake();
        wake_set = 1'b1;
        @(negedge clk);
        wake_set = 1'b0;
        @(negedge clk);
        chk("R5", "wake armed", wake_en, 1);
        send_frame(8'h33, 1, 0, 1);
        chk("R5", "dropped rdy", rdy, 0);
        chk("R5", "dropped data", rx_data, 8'h6E);
        chk("R5", "still armed", wake_en, 1);
        send_frame(8'h34, 1, 0, 0);
        chk("R5", "no fer on dropped", fer, 0);
        send_frame(8'h44, 1, 1, 1);
        chk("R6", "wake data", rx_data, 8'h44);
        chk("R6", "wake rdy", rdy, 1);
        chk("R6", "wake mpb", rx_mpb, 1);
        chk("R6", "auto disarm", wake_en, 0);
        read_data();
        send_frame(8'h55, 1, 0, 1);
        chk("R6", "normal after wake", rx_data, 8'h55);
        read_data();
    endtask

    task automatic t_mp_off();
        mp_fmt = 1'b0;
        par_en = 1'b1;
        par_odd = 1'b0;
        wake_set = 1'b1;
        @(negedge clk);
        wake_set = 1'b0;
        send_frame(8'h07, 1, 1, 1);
        chk("R7", "received with wake set", rx_data, 8'h07);
        chk("R7", "rdy", rdy, 1);
        chk("R7", "wake kept", wake_en, 1);
        chk("R9", "even parity ok", per, 0);
        read_data();
        send_frame(8'h0F, 1, 1, 1);
        chk("R9", "even parity bad", per, 1);
        chk("R9", "rdy on parity error", rdy, 0);
        clr_per = 1'b1;
        @(negedge clk);
        clr_per = 1'b0;
        @(negedge clk);
        chk("R12", "per cleared", per, 0);
        par_odd = 1'b1;
        send_frame(8'h07, 1, 0, 1);
        chk("R9", "odd parity ok", {per, rdy}, 2'b01);
        read_data();
        par_en = 1'b0;
        send_frame(8'h99, 0, 0, 1);
        chk("R9", "no extra bit data", rx_data, 8'h99);
        chk("R9", "no extra bit rdy", rdy, 1);
        read_data();
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_basic();
        t_glitch();
        t_overrun();
        t_framing();
        t_rxen_clear();
        t_wake();
        t_mp_off();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule